// File: doc/BRIEF.md
# Fully Associative Byte Cache

This block is a small cache in which any main-memory byte may occupy any entry. Each entry is one 40-bit word: the complete 32-bit byte address next to the 8-bit byte it holds, plus a valid flag. A lookup compares the requested address against every entry in the same cycle. The comparison goes through a constant key that covers only the address part of the word. A hit returns the stored byte one cycle after the request is accepted.

On a miss the block raises a read request toward a simple memory port and holds it until the memory answers. It then returns the fetched byte and writes it, with its address, into a victim entry. Empty entries are filled first, lowest index first. Once the cache is full, a parameter picks the victim policy. In first-in-first-out mode the oldest installed entry is replaced. In least-recently-used mode the entry that has gone longest without a hit or fill is replaced.

A client drives one request at a time while `req_ready` is high. It watches `rsp_valid` for a one-cycle response carrying the hit flag and the data byte.

Top module: `assoc_byte_cache`

## Requirements
- R1: A synchronous reset invalidates every entry. After reset `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first lookup of any address after reset is a miss.
- R2: A missed lookup raises `mem_req` in the cycle after acceptance, with `mem_addr` equal to the requested address. Both hold steady, and `req_ready` stays 0, until `mem_valid` is seen.
- R3: In the cycle after `mem_valid` is seen with a request outstanding, `rsp_valid` is 1, `rsp_hit` is 0, `rsp_data` equals the byte that came with `mem_valid`, and `mem_req` is 0. If a request for the same address is accepted in that response cycle, it hits.
- R4: A lookup that matches a valid entry gives `rsp_valid`=1, `rsp_hit`=1 and the stored byte in the cycle after acceptance, and raises no memory request.
- R5: Matching uses all 32 address bits and never the data byte. Addresses that differ from a resident address in bit 31 alone, or in bit 0 alone, miss.
- R6: While any entry is invalid, a fill goes to the lowest-indexed invalid entry, so the first ENTRIES distinct misses after reset all stay resident.
- R7: With POLICY = first-in-first-out (enum value 0), a fill into a full cache replaces the entry installed earliest, whatever hits it received.
- R8: With POLICY = least-recently-used (enum value 1), a fill into a full cache replaces the entry whose last hit or fill is oldest.
- R9: At most one entry matches any address. A hit allocates nothing and changes no entry's contents.
- R10: `rsp_valid` is a single-cycle pulse for each accepted request. A `mem_valid` pulse with no request outstanding produces no response and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Byte address to look up |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = served from cache, 0 = fetched from memory |
| rsp_data | output | DATA_W | Returned byte |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | ADDR_W | Address of the memory read |
| mem_valid | input | 1 | Memory read data strobe |
| mem_data | input | DATA_W | Memory read data |

## Verification
Two events can land in one cycle: completing a fill, and looking up a new request. In the cycle where the fill response is presented, the block is already idle, and the entry written at that edge must already take part in the parallel compare. The bench provokes this by issuing a miss and then asserting the same address again in exactly the response cycle. It judges the result by requiring a hit with the freshly fetched byte in the very next cycle and no second memory request. Two instances with opposite victim policies run one shared address sequence, and their differing hit patterns show the two replacement orders.

// File: rtl/abc_pkg.sv
package abc_pkg;

   typedef enum logic {
      VICT_FIFO = 1'b0,
      VICT_LRU  = 1'b1
   } victim_pol_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } cache_state_e;

endpackage

// File: rtl/abc_entry_array.sv
module abc_entry_array #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 8,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  lk_addr,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [ENTRIES-1:0] match_vec,
   output logic [ENTRIES-1:0] valid_vec,
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx,
   output logic [DATA_W-1:0]  hit_data
);
   localparam int WORD_W = ADDR_W + DATA_W;
   // constant key: address field exposed, data field masked off
   localparam logic [WORD_W-1:0] KEY = {{ADDR_W{1'b1}}, {DATA_W{1'b0}}};

   logic [WORD_W-1:0]  word_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q;
   logic [WORD_W-1:0]  arg;

   assign arg       = {lk_addr, {DATA_W{1'b0}}};
   assign valid_vec = valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(i))) begin
            word_q[i] <= {wr_addr, wr_data};
         end
      end
      assign match_vec[i] = valid_q[i] && (((word_q[i] ^ arg) & KEY) == '0);
   end

   // lowest-indexed match wins
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit      = |match_vec;
   assign hit_data = word_q[hit_idx][DATA_W-1:0];

endmodule

// File: rtl/abc_victim.sv
module abc_victim
   import abc_pkg::*;
#(
   parameter int          ENTRIES = 8,
   parameter victim_pol_e POLICY  = VICT_FIFO,
   localparam int         IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               touch_en,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic               fill_en,
   output logic [IDX_W-1:0]   victim_idx
);
   logic               any_free;
   logic [IDX_W-1:0]   free_idx;
   logic [IDX_W-1:0]   pol_idx;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   if (POLICY == VICT_FIFO) begin : g_fifo
      logic [IDX_W-1:0] ptr_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            ptr_q <= '0;
         end else if (fill_en) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
         end
      end
      assign pol_idx = ptr_q;
   end else begin : g_lru
      logic [IDX_W-1:0] age_q [ENTRIES];
      for (genvar i = 0; i < ENTRIES; i++) begin : g_age
         always_ff @(posedge clk) begin
            if (rst) begin
               age_q[i] <= IDX_W'(i);
            end else if (touch_en) begin
               if (touch_idx == IDX_W'(i)) begin
                  age_q[i] <= '0;
               end else if (age_q[i] < age_q[touch_idx]) begin
                  age_q[i] <= age_q[i] + 1'b1;
               end
            end
         end
      end
      always_comb begin
         pol_idx = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == IDX_W'(ENTRIES - 1)) pol_idx = IDX_W'(i);
         end
      end
   end

   assign victim_idx = any_free ? free_idx : pol_idx;

endmodule

// File: rtl/assoc_byte_cache.sv
module assoc_byte_cache
   import abc_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int          DATA_W  = 8,
   parameter int          ENTRIES = 8,
   parameter victim_pol_e POLICY  = VICT_FIFO
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("assoc_byte_cache: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("assoc_byte_cache: DATA_W must be at least 1");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("assoc_byte_cache: ENTRIES must be at least 2");
   end

   cache_state_e       state_q;
   logic [ADDR_W-1:0]  pend_addr_q;
   logic [IDX_W-1:0]   victim_q;
   logic               mem_req_q;
   logic               rsp_valid_q;
   logic               rsp_hit_q;
   logic [DATA_W-1:0]  rsp_data_q;

   logic [ENTRIES-1:0] match_vec;
   logic [ENTRIES-1:0] valid_vec;
   logic               hit;
   logic [IDX_W-1:0]   hit_idx;
   logic [DATA_W-1:0]  hit_data;
   logic [IDX_W-1:0]   victim_idx;
   logic               accept;
   logic               wr_en;
   logic               touch_en;
   logic [IDX_W-1:0]   touch_idx;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign wr_en     = (state_q == ST_FILL) && mem_valid;
   assign touch_en  = (accept && hit) || wr_en;
   assign touch_idx = wr_en ? victim_q : hit_idx;

   abc_entry_array #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .ENTRIES (ENTRIES)
   ) u_array (
      .clk       (clk),
      .rst       (rst),
      .lk_addr   (req_addr),
      .wr_en     (wr_en),
      .wr_idx    (victim_q),
      .wr_addr   (pend_addr_q),
      .wr_data   (mem_data),
      .match_vec (match_vec),
      .valid_vec (valid_vec),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .hit_data  (hit_data)
   );

   abc_victim #(
      .ENTRIES (ENTRIES),
      .POLICY  (POLICY)
   ) u_victim (
      .clk        (clk),
      .rst        (rst),
      .valid_vec  (valid_vec),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .fill_en    (wr_en),
      .victim_idx (victim_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         pend_addr_q <= '0;
         victim_q    <= '0;
         mem_req_q   <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_hit_q   <= 1'b1;
                     rsp_data_q  <= hit_data;
                  end else begin
                     state_q     <= ST_FILL;
                     mem_req_q   <= 1'b1;
                     pend_addr_q <= req_addr;
                     victim_q    <= victim_idx;
                  end
               end
            end
            ST_FILL: begin
               if (mem_valid) begin
                  state_q     <= ST_IDLE;
                  mem_req_q   <= 1'b0;
                  rsp_valid_q <= 1'b1;
                  rsp_hit_q   <= 1'b0;
                  rsp_data_q  <= mem_data;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = mem_req_q;
   assign mem_addr  = pend_addr_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_hit   = rsp_hit_q;
   assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/abc_cache_chk.sv
module abc_cache_chk #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 8
) (
   input logic               clk,
   input logic               rst,
   input logic [ENTRIES-1:0] match_vec,
   input logic               req_valid,
   input logic               req_ready,
   input logic               mem_req,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_valid,
   input logic               rsp_valid,
   input logic               rsp_hit
);
   p_single_match_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(match_vec));

   p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   p_busy_r2: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !req_ready);

   p_fill_rsp_r3: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_valid) |=> (rsp_valid && !rsp_hit && !mem_req));

   p_hit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_hit) |-> !mem_req);

   p_stray_r10: assert property (@(posedge clk) disable iff (rst)
      (!mem_req && mem_valid && !(req_valid && req_ready)) |=> !rsp_valid);

endmodule

bind assoc_byte_cache abc_cache_chk #(
   .ADDR_W  (ADDR_W),
   .ENTRIES (ENTRIES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .match_vec (match_vec),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_valid (mem_valid),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit)
);

// File: tb/assoc_byte_cache_tb.sv
`timescale 1ns/1ps
module assoc_byte_cache_tb;
   import abc_pkg::*;

   localparam int N_ROWS = 14;
   localparam logic [31:0] A0 = 32'h0000_1000;
   localparam logic [31:0] A1 = 32'h8000_1000; // bit 31 differs from A0 (R5)
   localparam logic [31:0] A2 = 32'h0000_1001; // bit 0 differs from A0 (R5)
   localparam logic [31:0] A3 = 32'hDEAD_BEEF;
   localparam logic [31:0] A4 = 32'h1234_5678;
   localparam logic [31:0] A5 = 32'h0BAD_F00D;
   localparam logic [31:0] A6 = 32'h7777_0123;

   // address, expected hit for FIFO instance, expected hit for LRU instance
   localparam logic [31:0] T_ADDR [N_ROWS] =
      '{A0, A1, A2, A3, A0, A4, A0, A1, A2, A3, A0, A4, A2, A1};
   localparam bit T_HF [N_ROWS] = '{0,0,0,0,1,0,0,0,0,0,1,0,1,1};
   localparam bit T_HL [N_ROWS] = '{0,0,0,0,1,0,1,0,0,0,1,0,1,0};

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [31:0] req_addr = '0;
   logic req_valid_f = 1'b0, req_valid_l = 1'b0;
   logic req_ready_f, req_ready_l, rsp_valid_f, rsp_valid_l, rsp_hit_f, rsp_hit_l;
   logic [7:0] rsp_data_f, rsp_data_l;
   logic mem_req_f, mem_req_l;
   logic [31:0] mem_addr_f, mem_addr_l;
   logic mv_f, mv_l;
   logic [7:0] md_f, md_l;
   logic inj = 1'b0;
   int lat = 0;
   int cnt_f, cnt_l;
   int checks = 0;
   int errors = 0;

   function automatic logic [7:0] fmem(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
   endfunction

   assoc_byte_cache #(.ENTRIES(4), .POLICY(VICT_FIFO)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid_f), .req_addr(req_addr),
      .req_ready(req_ready_f), .rsp_valid(rsp_valid_f), .rsp_hit(rsp_hit_f),
      .rsp_data(rsp_data_f), .mem_req(mem_req_f), .mem_addr(mem_addr_f),
      .mem_valid(mv_f | inj), .mem_data(inj ? 8'hEE : md_f));

   assoc_byte_cache #(.ENTRIES(4), .POLICY(VICT_LRU)) u_dut_lru (
      .clk(clk), .rst(rst), .req_valid(req_valid_l), .req_addr(req_addr),
      .req_ready(req_ready_l), .rsp_valid(rsp_valid_l), .rsp_hit(rsp_hit_l),
      .rsp_data(rsp_data_l), .mem_req(mem_req_l), .mem_addr(mem_addr_l),
      .mem_valid(mv_l), .mem_data(md_l));

   // memory models: answer after lat extra cycles
   always_ff @(posedge clk) begin
      if (rst) begin
         mv_f <= 1'b0; md_f <= '0; cnt_f <= 0;
      end else if (mem_req_f && !mv_f) begin
         if (cnt_f >= lat) begin
            mv_f <= 1'b1; md_f <= fmem(mem_addr_f); cnt_f <= 0;
         end else cnt_f <= cnt_f + 1;
      end else mv_f <= 1'b0;
   end
   always_ff @(posedge clk) begin
      if (rst) begin
         mv_l <= 1'b0; md_l <= '0; cnt_l <= 0;
      end else if (mem_req_l && !mv_l) begin
         if (cnt_l >= lat) begin
            mv_l <= 1'b1; md_l <= fmem(mem_addr_l); cnt_l <= 0;
         end else cnt_l <= cnt_l + 1;
      end else mv_l <= 1'b0;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   // lookup on both instances, table-driven (R3 R4 R7 R8)
   task automatic acc_both(input logic [31:0] a, input bit ehf, input bit ehl);
      bit got_f = 0, got_l = 0;
      @(negedge clk);
      req_addr = a; req_valid_f = 1'b1; req_valid_l = 1'b1;
      @(negedge clk);
      req_valid_f = 1'b0; req_valid_l = 1'b0;
      for (int c = 0; c < 40 && !(got_f && got_l); c++) begin
         if (!got_f && rsp_valid_f) begin
            got_f = 1;
            chk(rsp_hit_f == ehf, "R7 fifo hit flag", 32'(rsp_hit_f), 32'(ehf));
            chk(rsp_data_f == fmem(a), "R3 R4 fifo data", 32'(rsp_data_f), 32'(fmem(a)));
         end
         if (!got_l && rsp_valid_l) begin
            got_l = 1;
            chk(rsp_hit_l == ehl, "R8 lru hit flag", 32'(rsp_hit_l), 32'(ehl));
            chk(rsp_data_l == fmem(a), "R3 R4 lru data", 32'(rsp_data_l), 32'(fmem(a)));
         end
         if (!(got_f && got_l)) @(negedge clk);
      end
      chk(got_f && got_l, "R3 response seen", {30'd0, got_f, got_l}, 32'd3);
   endtask

   // lookup on the FIFO instance only
   task automatic acc_one(input logic [31:0] a, input bit eh, input string tag);
      bit got = 0;
      @(negedge clk);
      req_addr = a; req_valid_f = 1'b1;
      @(negedge clk);
      req_valid_f = 1'b0;
      for (int c = 0; c < 40 && !got; c++) begin
         if (rsp_valid_f) begin
            got = 1;
            chk(rsp_hit_f == eh, tag, 32'(rsp_hit_f), 32'(eh));
            chk(rsp_data_f == fmem(a), tag, 32'(rsp_data_f), 32'(fmem(a)));
            @(negedge clk);
            chk(!rsp_valid_f, "R10 single pulse", 32'(rsp_valid_f), 32'd0);
         end else @(negedge clk);
      end
      chk(got, tag, 32'(got), 32'd1);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1: idle outputs after reset
      chk(req_ready_f && !rsp_valid_f && !mem_req_f, "R1 reset outputs",
          {29'd0, req_ready_f, rsp_valid_f, mem_req_f}, 32'd4);
      chk(req_ready_l && !rsp_valid_l && !mem_req_l, "R1 reset outputs lru",
          {29'd0, req_ready_l, rsp_valid_l, mem_req_l}, 32'd4);

      // vector table; rows 0-3 fill free entries (R6), rows 1-2 near-miss (R5)
      for (int r = 0; r < N_ROWS; r++) acc_both(T_ADDR[r], T_HF[r], T_HL[r]);
      // FIFO now holds A1 A2 A3 A4 (oldest first)

      // R9: repeated hits allocate nothing, A2 still resident, A1 still oldest
      acc_one(A2, 1'b1, "R9 repeat hit");
      acc_one(A2, 1'b1, "R9 repeat hit");

      // R2: slow memory, request held
      lat = 4;
      @(negedge clk);
      req_addr = A5; req_valid_f = 1'b1;
      @(negedge clk);
      req_valid_f = 1'b0;
      for (int c = 0; c < 4; c++) begin
         chk(mem_req_f && mem_addr_f == A5, "R2 request held", mem_addr_f, A5);
         chk(!req_ready_f && !rsp_valid_f, "R2 busy",
             {30'd0, req_ready_f, rsp_valid_f}, 32'd0);
         @(negedge clk);
      end
      while (!rsp_valid_f) @(negedge clk);
      chk(!rsp_hit_f && rsp_data_f == fmem(A5), "R3 slow fill data",
          32'(rsp_data_f), 32'(fmem(A5)));
      chk(!mem_req_f, "R3 request dropped", 32'(mem_req_f), 32'd0);
      lat = 0;
      @(negedge clk);
      // FIFO: A1 evicted by A5 (R7)
      acc_one(A3, 1'b1, "R7 A3 still resident");

      // R10: stray memory strobe while idle
      @(negedge clk);
      inj = 1'b1;
      @(negedge clk);
      inj = 1'b0;
      chk(!rsp_valid_f, "R10 stray no response", 32'(rsp_valid_f), 32'd0);
      @(negedge clk);
      chk(!rsp_valid_f && !mem_req_f, "R10 stray quiet",
          {30'd0, rsp_valid_f, mem_req_f}, 32'd0);
      acc_one(A4, 1'b1, "R10 entry unchanged after stray");

      // R3: same address requested in the fill response cycle must hit
      @(negedge clk);
      req_addr = A6; req_valid_f = 1'b1;
      @(negedge clk);
      req_valid_f = 1'b0;
      while (!rsp_valid_f) @(negedge clk);
      chk(!rsp_hit_f, "R3 fill response", 32'(rsp_hit_f), 32'd0);
      req_valid_f = 1'b1; // accepted at next edge, in the response cycle
      @(negedge clk);
      req_valid_f = 1'b0;
      chk(rsp_valid_f && rsp_hit_f && rsp_data_f == fmem(A6), "R3 back-to-back hit",
          {rsp_valid_f, rsp_hit_f, 22'd0, rsp_data_f}, {2'b11, 22'd0, fmem(A6)});
      chk(!mem_req_f, "R3 no refetch", 32'(mem_req_f), 32'd0);

      // R1: reset invalidates everything
      do_reset();
      acc_one(A6, 1'b0, "R1 miss after reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule